// File: doc/BRIEF.md
# Single-Port RAM with Selectable Write Behaviour

This block is a synchronous single-port word memory that sits on a processor data bus. One address selects the word. Write data enters on its own input and read data leaves on its own output, so there is no bidirectional bus. Every read goes through a register that loads on the rising clock edge. There is no read enable: any edge without a write reads the addressed word.

A mode pin sets what the read register does on an edge where a write takes place. In write-first mode the register loads the word being stored. In hold mode the register keeps the word it last read. A processor that captures the RAM output on every cycle therefore sees no stray data after a store. The mode pin is sampled on every edge, so the behaviour can change from one cycle to the next.

A synchronous reset clears only the read register. The storage array is never reset, and its contents are undefined until each word has been written.

Top module: `wm_spram`

## Requirements
- R1: `rdata` changes only on a rising clock edge. A change on `addr` between edges leaves `rdata` unchanged until the next edge.
- R2: On an edge with `we` low and `rst` low, `rdata` loads the word stored at `addr`. No read enable is involved.
- R3: On an edge with `we` high, `rst` low and `mode_nc` = 0 (write-first), `wdata` is stored at `addr` and also appears on `rdata` after that same edge.
- R4: On an edge with `we` high, `rst` low and `mode_nc` = 1 (hold), `wdata` is stored at `addr` and `rdata` keeps its previous value.
- R5: On an edge with `rst` high, `rdata` becomes zero. Stored words are not changed by the reset.
- R6: In either mode, a read of an address on the edge right after a write to that address returns the newly written word.
- R7: `mode_nc` is sampled on every edge. Alternating it between consecutive writes gives the write-first or hold result chosen on each individual edge.
- R8: With the default parameters (1024 words of 16 bits, 10-bit address), every location stores its own word independently of the others.
- R9: A write on an edge with `rst` high still updates the storage array. The read register goes to zero on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset of the read register, active high |
| we | input | 1 | Write enable; when low the edge performs a read |
| mode_nc | input | 1 | Write behaviour: 0 = write-first, 1 = hold previous read |
| addr | input | ADDR_W (10) | Word address |
| wdata | input | DATA_W (16) | Write data |
| rdata | output | DATA_W (16) | Registered read data |

## Verification
The assertions assume that `we`, `mode_nc`, `addr` and `wdata` carry known values at every edge once reset has been released. The read-after-write property also assumes that the address is held for the following read. The bench drives every input on the falling edge from the moment reset starts, and it never reads a location before writing it. A reference array in the bench therefore predicts every read word, and the storage's undefined power-up contents never reach a compared value.

// File: rtl/wm_pkg.sv
package wm_pkg;

  // Behaviour of the read register on an edge that writes
  typedef enum logic {
    WM_WRITE_FIRST = 1'b0,
    WM_HOLD        = 1'b1
  } wm_mode_e;

  // Source chosen for the read register on each edge
  typedef enum logic [1:0] {
    SRC_CLEAR = 2'd0,
    SRC_ARRAY = 2'd1,
    SRC_WRITE = 2'd2,
    SRC_KEEP  = 2'd3
  } wm_src_e;

endpackage

// File: rtl/wm_storage.sv
// Word array: written on the clock edge, word at the address presented combinationally
module wm_storage #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] word
);

  logic [DATA_W-1:0] cells [DEPTH];

  // No reset on the array: its contents survive any reset
  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wr_data;
  end

  // Old contents at the address; a same-edge write is not visible here
  assign word = cells[addr];

endmodule

// File: rtl/wm_src_sel.sv
// Decides which value the read register takes on the coming edge
module wm_src_sel
  import wm_pkg::*;
(
  input  logic     rst,
  input  logic     we,
  input  wm_mode_e mode,
  output wm_src_e  src
);

  always_comb begin
    if (rst)                       src = SRC_CLEAR;
    else if (!we)                  src = SRC_ARRAY;
    else if (mode == WM_WRITE_FIRST) src = SRC_WRITE;
    else                           src = SRC_KEEP;
  end

endmodule

// File: rtl/wm_rd_reg.sv
// Read register loaded from the selected source
module wm_rd_reg
  import wm_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  wm_src_e           src,
  input  logic [DATA_W-1:0] array_word,
  input  logic [DATA_W-1:0] write_word,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    unique case (src)
      SRC_CLEAR: q <= '0;
      SRC_ARRAY: q <= array_word;
      SRC_WRITE: q <= write_word;
      SRC_KEEP:  q <= q;
    endcase
  end

endmodule

// File: rtl/wm_spram.sv
module wm_spram
  import wm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              mode_nc,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] array_word;
  wm_src_e           src;
  wm_mode_e          mode;

  assign mode = wm_mode_e'(mode_nc);

  wm_storage #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk     (clk),
    .wr_en   (we),
    .addr    (addr),
    .wr_data (wdata),
    .word    (array_word)
  );

  wm_src_sel u_sel (
    .rst  (rst),
    .we   (we),
    .mode (mode),
    .src  (src)
  );

  wm_rd_reg #(.DATA_W(DATA_W)) u_rd (
    .clk        (clk),
    .src        (src),
    .array_word (array_word),
    .write_word (wdata),
    .q          (rdata)
  );

endmodule

// File: rtl/wm_spram_chk.sv
module wm_spram_chk #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          we,
  input logic          mode_nc,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata
);

  // R5: reset clears the read register
  assert_rst_clear_R5: assert property (@(posedge clk)
    rst |=> (rdata == '0));

  // R3: write-first shows the stored word
  assert_write_first_R3: assert property (@(posedge clk) disable iff (rst)
    (we && !mode_nc) |=> (rdata == $past(wdata)));

  // R4: hold mode keeps the read register
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (we && mode_nc) |=> $stable(rdata));

  // R6: read right after a write to the same address returns the new word
  assert_raw_R6: assert property (@(posedge clk) disable iff (rst)
    (!we && $past(we) && !$past(rst) && addr == $past(addr))
      |=> (rdata == $past(wdata, 2)));

endmodule

bind wm_spram wm_spram_chk #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .we      (we),
  .mode_nc (mode_nc),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata)
);

// File: tb/sim_wm_spram.sv
`timescale 1ns/1ps
module sim_wm_spram;

  localparam int DW    = 16;
  localparam int DEPTH = 1024;
  localparam int AW    = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          we = 1'b0;
  logic          mode_nc = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  logic [DW-1:0] ref_mem [DEPTH];
  logic [DW-1:0] last_rd;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  wm_spram #(.DATA_W(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .we(we), .mode_nc(mode_nc),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  function automatic logic [DW-1:0] pat(input int a, input int salt);
    return DW'((a * 40503) ^ (salt * 9973) ^ 16'h5AC3);
  endfunction

  task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, cross one rising edge, return at the next falling edge
  task automatic cyc(input logic w, input logic m, input int a, input logic [DW-1:0] d);
    we = w; mode_nc = m; addr = AW'(a); wdata = d;
    @(negedge clk);
    if (w) ref_mem[a] = d;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    cyc(1'b0, 1'b0, 0, '0);
    cyc(1'b0, 1'b0, 0, '0);
    chk("R5 reset value", rdata, '0);
    rst = 1'b0;
  endtask

  task automatic t_fill_write_first();
    for (int a = 0; a < DEPTH; a++) begin
      cyc(1'b1, 1'b0, a, pat(a, 1));
      if (a == 0 || a == DEPTH-1 || a == 517)
        chk("R3 write-first output", rdata, pat(a, 1));
    end
  endtask

  task automatic t_readback();
    int bad = 0;
    for (int a = DEPTH-1; a >= 0; a--) begin
      cyc(1'b0, 1'b0, a, 16'hFFFF);
      if (rdata !== ref_mem[a]) begin
        bad++;
        chk("R8 location readback", rdata, ref_mem[a]);
      end
    end
    chk("R2 full readback ok", DW'(bad), '0);
  endtask

  task automatic t_addr_between_edges();
    cyc(1'b0, 1'b0, 10, '0);
    chk("R1 read word", rdata, ref_mem[10]);
    addr = AW'(900);
    #2;
    chk("R1 stable between edges", rdata, ref_mem[10]);
    @(negedge clk);
    chk("R1 next edge loads", rdata, ref_mem[900]);
  endtask

  task automatic t_hold_mode();
    cyc(1'b0, 1'b0, 33, '0);
    last_rd = ref_mem[33];
    chk("R2 read before hold", rdata, last_rd);
    cyc(1'b1, 1'b1, 34, 16'hBEEF);
    chk("R4 hold after write", rdata, last_rd);
    cyc(1'b1, 1'b1, 35, 16'h1234);
    chk("R4 hold after second write", rdata, last_rd);
    cyc(1'b0, 1'b1, 34, '0);
    chk("R6 hold-mode read after write", rdata, 16'hBEEF);
  endtask

  task automatic t_raw_write_first();
    cyc(1'b1, 1'b0, 600, 16'hA55A);
    cyc(1'b0, 1'b0, 600, '0);
    chk("R6 write-first read after write", rdata, 16'hA55A);
  endtask

  task automatic t_mode_toggle();
    cyc(1'b0, 1'b0, 100, '0);
    last_rd = rdata;
    for (int i = 0; i < 6; i++) begin
      logic m = logic'(i[0]);
      cyc(1'b1, m, 200 + i, pat(i, 7));
      if (!m) last_rd = pat(i, 7);
      chk("R7 per-edge mode", rdata, last_rd);
    end
    for (int i = 0; i < 6; i++) begin
      cyc(1'b0, 1'b0, 200 + i, '0);
      chk("R7 stored by toggled writes", rdata, pat(i, 7));
    end
  endtask

  task automatic t_reset_keeps_memory();
    cyc(1'b0, 1'b0, 700, '0);
    rst = 1'b1;
    cyc(1'b1, 1'b0, 701, 16'h0F0F);
    chk("R9 output zero while writing in reset", rdata, '0);
    cyc(1'b0, 1'b0, 700, '0);
    chk("R5 output zero during reset", rdata, '0);
    rst = 1'b0;
    cyc(1'b0, 1'b0, 700, '0);
    chk("R5 memory kept through reset", rdata, ref_mem[700]);
    cyc(1'b0, 1'b0, 701, '0);
    chk("R9 write during reset stored", rdata, 16'h0F0F);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_write_first();
    t_readback();
    t_addr_between_edges();
    t_hold_mode();
    t_raw_write_first();
    t_mode_toggle();
    t_reset_keeps_memory();
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule